// File: doc/BRIEF.md
# Byte ALU with Post-Shift

This block is the combinational arithmetic and logic stage of a small 8-bit processor datapath. It takes two byte operands and a carry flag, and applies one of eight operations chosen by a 3-bit code. It can then shift the result right by one place, either logically or arithmetically. It returns the final byte, a carry/borrow bit for the carry flag register, and a zero indication for the zero flag register.

The surrounding datapath picks the operands. The X operand comes from a source register, the target register or memory data. The Y operand comes from the accumulator register, or from an 8-bit immediate in the immediate form, where the target register supplies X. Register selection, write-back and instruction sequencing sit outside this block. The block has no state, so every output follows its inputs within the same cycle.

Top module: `byte_alu_shift`

## Requirements
- R1: Operation code 000 gives result = (X + Y) mod 256 and carry_out = carry out of bit 7; carry_in has no effect.
- R2: Operation code 001 gives result = (X + Y + carry_in) mod 256 and carry_out = carry out of bit 7.
- R3: Operation code 010 gives result = (X - (Y + carry_in)) mod 256. carry_out is 1 exactly when Y + carry_in, taken as a 9-bit value, exceeds X, and this includes Y = 0xFF with carry_in = 1.
- R4: Operation code 011 passes X and code 111 passes Y unchanged; both give carry_out = 0.
- R5: Operation codes 100, 101 and 110 give the bitwise XOR, OR and AND of X and Y respectively, with carry_out = 0.
- R6: Shift code 01 shifts the operation result right by one, with 0 entering bit 7, and carry_out becomes the result's former bit 0.
- R7: Shift code 10 shifts the operation result right by one while keeping bit 7 unchanged, and carry_out becomes the result's former bit 0.
- R8: Shift codes 00 and 11 leave the operation result and its carry_out unchanged.
- R9: zero_out is 1 exactly when the final (post-shift) result is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 8 | Operand X (register, immediate target or memory data) |
| y_in | input | 8 | Operand Y (accumulator or immediate) |
| carry_in | input | 1 | Current carry flag |
| op_sel | input | 3 | Operation code |
| shift_sel | input | 2 | Post-shift code |
| result | output | 8 | Final result after the optional shift |
| carry_out | output | 1 | New carry flag value |
| zero_out | output | 1 | New zero flag value |

## Verification
On every evaluation, the embedded assertions check the inverse arithmetic of the add and subtract paths, the borrow condition, and the cleared carry of logic and move operations. They also check each shift mode's bit movement and carry capture, and that a zero flag fits the pre-shift value. What these checks cannot show is that the operation and shift codes map to the right behaviour, or that the two stages meet correctly in corner cases. Examples are a carry replaced by a shifted-out bit, a borrow when Y plus carry reaches 256, and a result that becomes zero only after shifting. The bench's vector table and its code-by-operand sweep cover those.

// File: rtl/bas_pkg.sv
package bas_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_ADC  = 3'b001,
    OP_SBC  = 3'b010,
    OP_MOVX = 3'b011,
    OP_XOR  = 3'b100,
    OP_OR   = 3'b101,
    OP_AND  = 3'b110,
    OP_MOVY = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_LSR  = 2'b01,
    SH_ASR  = 2'b10,
    SH_KEEP = 2'b11
  } shift_e;

  function automatic logic uses_carry_in(alu_op_e op);
    return (op == OP_ADC) || (op == OP_SBC);
  endfunction

  function automatic logic is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SBC);
  endfunction

  function automatic logic is_shifting(shift_e sh);
    return (sh == SH_LSR) || (sh == SH_ASR);
  endfunction

endpackage

// File: rtl/bas_opunit.sv
module bas_opunit
  import bas_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] r_o,
  output logic         c_o
);
  localparam int EW = W + 1;

  logic          cin_eff;
  logic [EW-1:0] sum_w;
  logic [EW-1:0] sub_w;
  logic [EW-1:0] subtrahend_w;

  always_comb begin
    cin_eff      = uses_carry_in(op_i) & c_i;
    subtrahend_w = {1'b0, y_i} + EW'(cin_eff);
    sum_w        = {1'b0, x_i} + {1'b0, y_i} + EW'(cin_eff);
    sub_w        = {1'b0, x_i} - subtrahend_w;
  end

  always_comb begin
    r_o = '0;
    c_o = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC: begin r_o = sum_w[W-1:0]; c_o = sum_w[W]; end
      OP_SBC:         begin r_o = sub_w[W-1:0]; c_o = sub_w[W]; end
      OP_MOVX:        r_o = x_i;
      OP_XOR:         r_o = x_i ^ y_i;
      OP_OR:          r_o = x_i | y_i;
      OP_AND:         r_o = x_i & y_i;
      OP_MOVY:        r_o = y_i;
      default:        r_o = '0;
    endcase
  end

  // Assertions next to the arithmetic they guard
  always_comb begin
    if (op_i == OP_ADD) begin
      p_add_inverse_r1: assert (W'(r_o - y_i) == x_i && c_o == (EW'(x_i) + EW'(y_i) > EW'({W{1'b1}})));
    end
    if (op_i == OP_ADC) begin
      p_adc_inverse_r2: assert (W'(r_o - y_i - W'(c_i)) == x_i);
    end
    if (op_i == OP_SBC) begin
      p_sbc_inverse_r3: assert (W'(r_o + y_i + W'(c_i)) == x_i);
      p_sbc_borrow_r3:  assert (c_o == ((EW'(y_i) + EW'(c_i)) > EW'(x_i)));
    end
    if (!is_arith(op_i)) begin
      p_logic_no_carry_r5: assert (c_o == 1'b0);
    end
  end

endmodule

// File: rtl/bas_shifter.sv
module bas_shifter
  import bas_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] v_i,
  input  logic         c_i,
  input  shift_e       sh_i,
  output logic [W-1:0] v_o,
  output logic         c_o
);
  logic [W-1:0] shifted_w;
  logic         fill_w;

  assign fill_w = (sh_i == SH_ASR) ? v_i[W-1] : 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign shifted_w[i] = fill_w;
    end else begin : g_low
      assign shifted_w[i] = v_i[i+1];
    end
  end

  always_comb begin
    if (is_shifting(sh_i)) begin
      v_o = shifted_w;
      c_o = v_i[0];
    end else begin
      v_o = v_i;
      c_o = c_i;
    end
  end

  always_comb begin
    if (sh_i == SH_LSR) begin
      p_lsr_msb_clear_r6: assert (v_o[W-1] == 1'b0 && {v_o, c_o} == {1'b0, v_i});
    end
    if (sh_i == SH_ASR) begin
      p_asr_keeps_sign_r7: assert (v_o[W-1] == v_i[W-1] && {v_o[W-2:0], c_o} == v_i);
    end
    if (!is_shifting(sh_i)) begin
      p_pass_through_r8: assert (v_o == v_i && c_o == c_i);
    end
  end

endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift
  import bas_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         carry_in,
  input  logic [2:0]   op_sel,
  input  logic [1:0]   shift_sel,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero_out
);
  alu_op_e      op_w;
  shift_e       sh_w;
  logic [W-1:0] op_res_w;
  logic         op_carry_w;

  assign op_w = alu_op_e'(op_sel);
  assign sh_w = shift_e'(shift_sel);

  bas_opunit #(.W(W)) u_op (
    .x_i  (x_in),
    .y_i  (y_in),
    .c_i  (carry_in),
    .op_i (op_w),
    .r_o  (op_res_w),
    .c_o  (op_carry_w)
  );

  bas_shifter #(.W(W)) u_sh (
    .v_i  (op_res_w),
    .c_i  (op_carry_w),
    .sh_i (sh_w),
    .v_o  (result),
    .c_o  (carry_out)
  );

  assign zero_out = ~|result;

  // Zero flag must agree with the value that entered the shifter
  always_comb begin
    if (zero_out && !is_shifting(sh_w)) begin
      p_zero_unshifted_r9: assert (op_res_w == '0);
    end
    if (zero_out && sh_w == SH_LSR) begin
      p_zero_after_lsr_r9: assert (op_res_w[W-1:1] == '0);
    end
    if (zero_out && sh_w == SH_ASR) begin
      p_zero_after_asr_r9: assert (op_res_w[W-1:1] == '0);
    end
  end

endmodule

// File: tb/byte_alu_shift_test.sv
module byte_alu_shift_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] x_in = '0, y_in = '0;
  logic       carry_in = 1'b0;
  logic [2:0] op_sel = '0;
  logic [1:0] shift_sel = '0;
  logic [7:0] result;
  logic       carry_out, zero_out;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  byte_alu_shift uut (
    .x_in(x_in), .y_in(y_in), .carry_in(carry_in), .op_sel(op_sel),
    .shift_sel(shift_sel), .result(result), .carry_out(carry_out), .zero_out(zero_out)
  );

  // entry: op(3) shift(2) cin(1) x(8) y(8) | result(8) carry(1) zero(1)
  localparam int NV = 20;
  localparam logic [31:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b1, 8'h10, 8'h20, 8'h30, 1'b0, 1'b0},  // R1 cin ignored
    {3'd0, 2'd0, 1'b0, 8'hF0, 8'h10, 8'h00, 1'b1, 1'b1},  // R1 carry out
    {3'd1, 2'd0, 1'b1, 8'h7F, 8'h00, 8'h80, 1'b0, 1'b0},  // R2
    {3'd1, 2'd0, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1},  // R2 carry ripple
    {3'd2, 2'd0, 1'b1, 8'h50, 8'h20, 8'h2F, 1'b0, 1'b0},  // R3
    {3'd2, 2'd0, 1'b1, 8'h10, 8'h10, 8'hFF, 1'b1, 1'b0},  // R3 borrow from cin
    {3'd2, 2'd0, 1'b1, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b1},  // R3 Y+cin = 256
    {3'd3, 2'd0, 1'b1, 8'hA5, 8'h3C, 8'hA5, 1'b0, 1'b0},  // R4 pass X
    {3'd4, 2'd0, 1'b1, 8'hA5, 8'h3C, 8'h99, 1'b0, 1'b0},  // R5 xor
    {3'd5, 2'd0, 1'b1, 8'hA0, 8'h05, 8'hA5, 1'b0, 1'b0},  // R5 or
    {3'd6, 2'd0, 1'b1, 8'hA5, 8'h5A, 8'h00, 1'b0, 1'b1},  // R5 and
    {3'd7, 2'd0, 1'b1, 8'h11, 8'h77, 8'h77, 1'b0, 1'b0},  // R4 pass Y
    {3'd7, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1},  // R4 pass Y zero
    {3'd0, 2'd1, 1'b0, 8'h81, 8'h00, 8'h40, 1'b1, 1'b0},  // R6
    {3'd0, 2'd2, 1'b0, 8'h81, 8'h00, 8'hC0, 1'b1, 1'b0},  // R7
    {3'd0, 2'd1, 1'b0, 8'h80, 8'h80, 8'h00, 1'b0, 1'b1},  // R6 add carry replaced
    {3'd2, 2'd2, 1'b0, 8'h00, 8'h01, 8'hFF, 1'b1, 1'b0},  // R7 negative stays
    {3'd3, 2'd1, 1'b0, 8'h01, 8'h00, 8'h00, 1'b1, 1'b1},  // R9 zero after shift
    {3'd3, 2'd3, 1'b1, 8'h42, 8'h00, 8'h42, 1'b0, 1'b0},  // R8 code 11
    {3'd3, 2'd2, 1'b0, 8'h7E, 8'h00, 8'h3F, 1'b0, 1'b0}   // R7 positive
  };
  localparam string VTAG [NV] = '{"R1","R1","R2","R2","R3","R3","R3","R4","R5","R5",
                                  "R5","R4","R4","R6","R7","R6","R7","R9","R8","R7"};

  function automatic logic [9:0] model(int op, int sh, int ci, int x, int y);
    int a; int r; int c;
    c = 0;
    case (op)
      0: begin a = x + y;      r = a % 256; c = (a > 255); end
      1: begin a = x + y + ci; r = a % 256; c = (a > 255); end
      2: begin a = x - y - ci; r = (a + 512) % 256; c = (a < 0); end
      3: r = x;
      4: r = x ^ y;
      5: r = x | y;
      6: r = x & y;
      default: r = y;
    endcase
    if (sh == 1 || sh == 2) begin
      c = r % 2;
      r = r / 2 + ((sh == 2 && r >= 128) ? 128 : 0);
    end
    return {r[7:0], c[0], (r == 0)};
  endfunction

  task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual res=%h c=%b z=%b expected res=%h c=%b z=%b",
               tag, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(int op, int sh, int ci, int x, int y);
    @(posedge clk);
    #1;
    op_sel = 3'(op); shift_sel = 2'(sh); carry_in = ci[0]; x_in = 8'(x); y_in = 8'(y);
    @(negedge clk);
  endtask

  function automatic string sweep_tag(int op, int sh);
    if (sh == 1) return "R6";
    if (sh == 2) return "R7";
    case (op)
      0: return "R1 R8";
      1: return "R2 R8";
      2: return "R3 R8";
      3, 7: return "R4 R8";
      default: return "R5 R8";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // all-zero inputs after reset: 0 + 0 gives zero, no carry
    chk("R9 reset", {result, carry_out, zero_out}, {8'h00, 1'b0, 1'b1});

    for (int i = 0; i < NV; i++) begin
      apply(int'(VEC[i][31:29]), int'(VEC[i][28:27]), int'(VEC[i][26]),
            int'(VEC[i][25:18]), int'(VEC[i][17:10]));
      chk(VTAG[i], {result, carry_out, zero_out}, VEC[i][9:0]);
    end

    for (int op = 0; op < 8; op++)
      for (int sh = 0; sh < 4; sh++)
        for (int ci = 0; ci < 2; ci++)
          for (int xi = 0; xi < 5; xi++)
            for (int yi = 0; yi < 5; yi++) begin
              int xv; int yv;
              xv = (xi == 0) ? 0 : (xi == 1) ? 1 : (xi == 2) ? 127 : (xi == 3) ? 128 : 255;
              yv = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 127 : (yi == 3) ? 128 : 255;
              apply(op, sh, ci, xv, yv);
              chk(sweep_tag(op, sh), {result, carry_out, zero_out}, model(op, sh, ci, xv, yv));
            end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule